// File: doc/BRIEF.md
# Call/return stack sequencer

This unit carries out the stack half of control transfers for an 8-bit processor with a 16-bit program counter and a 16-bit stack pointer. On a start strobe it takes in several values:

- an operation code
- the current program counter
- the current stack pointer
- the status byte
- a register pair
- a target address

It then walks through a fixed list of single-byte memory writes and reads, one per clock. At the end it presents the new program counter, stack pointer, status byte and popped pair, together with a one-cycle completion strobe.

Three groups of operations are supported. Calls and the software break save a return address, and the break also saves the status byte. Returns restore the program counter, and two of them also restore the status byte. Push and pop move a register pair through the stack. The instruction fetch, the decoder and any interrupt priority logic sit outside and only see the start/done handshake and the result ports. Memory reads are asynchronous: `mem_rdata` must reflect `mem_addr` in the same cycle that `mem_re` is high.

Top module: `callstack_seq`

## Requirements
- R1: Operation codes are 0 absolute call, 1 fixed-area call, 2 table call, 3 software break, 4 subroutine return, 5 interrupt return, 6 break return, 7 push pair, 8 pop pair. A start with code 9 to 15 is ignored: it makes no memory access, raises no done and leaves busy low.
- R2: Calls 0 and 1 push a return address of pc_in+3 and pc_in+2 respectively. The high byte goes to SP−1 and the low byte to SP−2. The result is sp_out=SP−2, pc_out=target_in and psw_out=psw_in.
- R3: The table call pushes pc_in+1 as in R2. It then reads pc_out low from address {8'h00, target_in[7:0]} and pc_out high from the next address. The result is sp_out=SP−2.
- R4: The software break writes psw_in to SP−1, the high byte of pc_in+1 to SP−2 and its low byte to SP−3. It then reads pc_out low from 003EH and high from 003FH. The result is sp_out=SP−3.
- R5: A subroutine return reads pc_out low from SP and high from SP+1. The result is sp_out=SP+2.
- R6: An interrupt return reads the same two bytes as R5 and then reads psw_out from SP+2. The result is sp_out=SP+3, and nmi_clr pulses in the same cycle as done.
- R7: A break return restores the same three bytes as R6 with sp_out=SP+3, but leaves nmi_clr low.
- R8: Push pair writes pair_in[15:8] to SP−1 and pair_in[7:0] to SP−2. The result is sp_out=SP−2, with pc_out=pc_in and psw_out=psw_in.
- R9: Pop pair reads pair_out low from SP and high from SP+1. The result is sp_out=SP+2 and pc_out=pc_in. pair_out is changed by no other operation.
- R10: Each cycle carries at most one byte access, and reads and writes never coincide. The number of accesses per operation code 0..8 is 2,2,4,5,2,3,3,2,2, one in each consecutive cycle after acceptance. done is high for exactly the one cycle after the last access, and sp_out changes only as done rises.
- R11: A start raised while busy is ignored and does not alter the running operation or its results.
- R12: All stack pointer and stack address arithmetic wraps modulo 2^16.
- R13: After reset, busy, done, nmi_clr, mem_we and mem_re are low, and pc_out, sp_out, psw_out and pair_out are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation (taken only while idle) |
| op | input | 4 | Operation code (R1) |
| pc_in | input | 16 | Program counter of the current instruction |
| psw_in | input | 8 | Current status byte |
| sp_in | input | 16 | Current stack pointer |
| pair_in | input | 16 | Register pair to push |
| target_in | input | 16 | Call target, or table pointer in its low byte |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion strobe |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 16 | Resulting stack pointer |
| psw_out | output | 8 | Resulting status byte |
| pair_out | output | 16 | Last popped register pair |
| nmi_clr | output | 1 | Clear request for the non-maskable in-service flag |
| mem_addr | output | 16 | Byte address of the current access |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_re |

## Verification
Random operation codes are drawn with random stack pointers, program counters, status bytes, pairs and table pointers, over a memory that is already filled with random bytes. This separates the byte order of each push and pop, and it separates the different return-address offsets of the three calls. Directed cases put the stack pointer at 0001H and at FFFEH so that the stack crosses the top of the address space, which exposes missing wrap-around. Other directed cases issue an illegal code, and raise start repeatedly during a break to check that a running sequence is not disturbed. After every operation the access count, the done timing and the nmi_clr pulse are compared against the code's expected values. These catch extra or missing bytes, and any mix-up between the interrupt return and the break return.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

   localparam int unsigned OP_COUNT = 9;

   typedef enum logic [3:0] {
      OP_CALL_ABS  = 4'd0,
      OP_CALL_FIX  = 4'd1,
      OP_CALL_TBL  = 4'd2,
      OP_BREAK     = 4'd3,
      OP_RET_SUB   = 4'd4,
      OP_RET_INT   = 4'd5,
      OP_RET_BRK   = 4'd6,
      OP_PUSH_PAIR = 4'd7,
      OP_POP_PAIR  = 4'd8
   } cseq_op_e;

   // where a byte fetched during a step is stored
   typedef enum logic [2:0] {
      DST_NONE,
      DST_PC_LO,
      DST_PC_HI,
      DST_STAT,
      DST_PAIR_LO,
      DST_PAIR_HI
   } cseq_dst_e;

   function automatic logic op_legal(input logic [3:0] code);
      return 32'(code) < OP_COUNT;
   endfunction

   // distance from the instruction address to the saved return address
   function automatic logic [1:0] ret_len(input logic [3:0] code);
      case (code)
         4'd0:    return 2'd3;
         4'd1:    return 2'd2;
         default: return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/cseq_step_plan.sv
module cseq_step_plan
   import cseq_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned DW       = 8,
   parameter int unsigned SW       = 3,
   parameter int unsigned VEC_ADDR = 'h3E
) (
   input  cseq_op_e          op,
   input  logic [SW-1:0]     step,
   input  logic [AW-1:0]     sp,
   input  logic [AW-1:0]     ret_pc,
   input  logic [AW-1:0]     tbl_addr,
   input  logic [DW-1:0]     stat,
   input  logic [2*DW-1:0]   pair,
   output logic [AW-1:0]     addr,
   output logic              acc_we,
   output logic [DW-1:0]     acc_wdata,
   output cseq_dst_e         dst,
   output logic              last
);
   localparam logic [AW-1:0] K1  = AW'(1);
   localparam logic [AW-1:0] K2  = AW'(2);
   localparam logic [AW-1:0] K3  = AW'(3);
   localparam logic [AW-1:0] VEC = AW'(VEC_ADDR);

   logic [2*DW-1:0] push_word;
   logic            is_pop;

   assign push_word = (op == OP_PUSH_PAIR) ? pair : ret_pc;
   assign is_pop    = (op == OP_POP_PAIR);

   always_comb begin
      addr      = sp;
      acc_we    = 1'b0;
      acc_wdata = '0;
      dst       = DST_NONE;
      last      = 1'b0;
      case (op)
         OP_CALL_ABS, OP_CALL_FIX, OP_CALL_TBL, OP_PUSH_PAIR: begin
            case (step)
               SW'(0): begin
                  addr = sp - K1; acc_we = 1'b1; acc_wdata = push_word[2*DW-1:DW];
               end
               SW'(1): begin
                  addr = sp - K2; acc_we = 1'b1; acc_wdata = push_word[DW-1:0];
                  last = (op != OP_CALL_TBL);
               end
               SW'(2): begin
                  addr = tbl_addr; dst = DST_PC_LO;
               end
               default: begin
                  addr = tbl_addr + K1; dst = DST_PC_HI; last = 1'b1;
               end
            endcase
         end
         OP_BREAK: begin
            case (step)
               SW'(0): begin
                  addr = sp - K1; acc_we = 1'b1; acc_wdata = stat;
               end
               SW'(1): begin
                  addr = sp - K2; acc_we = 1'b1; acc_wdata = ret_pc[2*DW-1:DW];
               end
               SW'(2): begin
                  addr = sp - K3; acc_we = 1'b1; acc_wdata = ret_pc[DW-1:0];
               end
               SW'(3): begin
                  addr = VEC; dst = DST_PC_LO;
               end
               default: begin
                  addr = VEC + K1; dst = DST_PC_HI; last = 1'b1;
               end
            endcase
         end
         default: begin
            case (step)
               SW'(0): begin
                  addr = sp; dst = is_pop ? DST_PAIR_LO : DST_PC_LO;
               end
               SW'(1): begin
                  addr = sp + K1; dst = is_pop ? DST_PAIR_HI : DST_PC_HI;
                  last = (op == OP_RET_SUB) || is_pop;
               end
               default: begin
                  addr = sp + K2; dst = DST_STAT; last = 1'b1;
               end
            endcase
         end
      endcase
   end

endmodule

// File: rtl/cseq_capture.sv
module cseq_capture
   import cseq_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            preset,
   input  logic [AW-1:0]   preset_pc,
   input  logic [DW-1:0]   preset_stat,
   input  logic            take,
   input  cseq_dst_e       dst,
   input  logic [DW-1:0]   rdata,
   output logic [AW-1:0]   pc_q,
   output logic [DW-1:0]   stat_q,
   output logic [2*DW-1:0] pair_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         stat_q <= '0;
         pair_q <= '0;
      end else if (preset) begin
         pc_q   <= preset_pc;
         stat_q <= preset_stat;
      end else if (take) begin
         case (dst)
            DST_PC_LO:   pc_q[DW-1:0]      <= rdata;
            DST_PC_HI:   pc_q[2*DW-1:DW]   <= rdata;
            DST_STAT:    stat_q            <= rdata;
            DST_PAIR_LO: pair_q[DW-1:0]    <= rdata;
            DST_PAIR_HI: pair_q[2*DW-1:DW] <= rdata;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/callstack_seq.sv
module callstack_seq
   import cseq_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned DW       = 8,
   parameter int unsigned VEC_ADDR = 'h3E
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [3:0]      op,
   input  logic [AW-1:0]   pc_in,
   input  logic [DW-1:0]   psw_in,
   input  logic [AW-1:0]   sp_in,
   input  logic [2*DW-1:0] pair_in,
   input  logic [AW-1:0]   target_in,
   output logic            busy,
   output logic            done,
   output logic [AW-1:0]   pc_out,
   output logic [AW-1:0]   sp_out,
   output logic [DW-1:0]   psw_out,
   output logic [2*DW-1:0] pair_out,
   output logic            nmi_clr,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_we,
   output logic            mem_re,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata
);
   localparam int unsigned MAX_STEPS = 5;
   localparam int unsigned SW        = $clog2(MAX_STEPS);

   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("program counter must be exactly two bytes wide");
      end
      if (VEC_ADDR + 1 >= (1 << AW)) begin : g_bad_vec
         $error("break vector word must lie inside the address space");
      end
   endgenerate

   logic            busy_q, done_q, nmi_q;
   logic [SW-1:0]   step_q;
   cseq_op_e        op_q;
   logic [AW-1:0]   sp_q, ret_q, tbl_q, sp_out_q, sp_next;
   logic [DW-1:0]   stat_lat;
   logic [2*DW-1:0] pair_lat;

   logic            accept, direct_call;
   logic [AW-1:0]   pl_addr;
   logic            pl_we, pl_last;
   logic [DW-1:0]   pl_wdata;
   cseq_dst_e       pl_dst;

   assign accept      = start && !busy_q && op_legal(op);
   assign direct_call = (op == 4'(OP_CALL_ABS)) || (op == 4'(OP_CALL_FIX));

   always_comb begin
      case (op_q)
         OP_BREAK:                 sp_next = sp_q - AW'(3);
         OP_RET_SUB, OP_POP_PAIR:  sp_next = sp_q + AW'(2);
         OP_RET_INT, OP_RET_BRK:   sp_next = sp_q + AW'(3);
         default:                  sp_next = sp_q - AW'(2);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         nmi_q    <= 1'b0;
         step_q   <= '0;
         op_q     <= OP_CALL_ABS;
         sp_q     <= '0;
         ret_q    <= '0;
         tbl_q    <= '0;
         stat_lat <= '0;
         pair_lat <= '0;
         sp_out_q <= '0;
      end else begin
         done_q <= 1'b0;
         nmi_q  <= 1'b0;
         if (accept) begin
            busy_q   <= 1'b1;
            step_q   <= '0;
            op_q     <= cseq_op_e'(op);
            sp_q     <= sp_in;
            ret_q    <= pc_in + AW'(ret_len(op));
            tbl_q    <= AW'(target_in[DW-1:0]);
            stat_lat <= psw_in;
            pair_lat <= pair_in;
         end else if (busy_q) begin
            step_q <= step_q + SW'(1);
            if (pl_last) begin
               busy_q   <= 1'b0;
               done_q   <= 1'b1;
               nmi_q    <= (op_q == OP_RET_INT);
               sp_out_q <= sp_next;
            end
         end
      end
   end

   cseq_step_plan #(
      .AW(AW), .DW(DW), .SW(SW), .VEC_ADDR(VEC_ADDR)
   ) u_plan (
      .op        (op_q),
      .step      (step_q),
      .sp        (sp_q),
      .ret_pc    (ret_q),
      .tbl_addr  (tbl_q),
      .stat      (stat_lat),
      .pair      (pair_lat),
      .addr      (pl_addr),
      .acc_we    (pl_we),
      .acc_wdata (pl_wdata),
      .dst       (pl_dst),
      .last      (pl_last)
   );

   cseq_capture #(.AW(AW), .DW(DW)) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .preset      (accept),
      .preset_pc   (direct_call ? target_in : pc_in),
      .preset_stat (psw_in),
      .take        (mem_re),
      .dst         (pl_dst),
      .rdata       (mem_rdata),
      .pc_q        (pc_out),
      .stat_q      (psw_out),
      .pair_q      (pair_out)
   );

   assign busy      = busy_q;
   assign done      = done_q;
   assign nmi_clr   = nmi_q;
   assign sp_out    = sp_out_q;
   assign mem_addr  = pl_addr;
   assign mem_we    = busy_q && pl_we;
   assign mem_re    = busy_q && !pl_we && (pl_dst != DST_NONE);
   assign mem_wdata = pl_wdata;

endmodule

// File: rtl/cseq_checker.sv
module cseq_checker #(
   parameter int unsigned AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          nmi_clr,
   input logic          mem_we,
   input logic          mem_re,
   input logic [AW-1:0] sp_out
);

   assert_single_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_sp_settles_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(sp_out));

   assert_nmi_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_clr |-> done);

endmodule

bind callstack_seq cseq_checker #(.AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .nmi_clr (nmi_clr),
   .mem_we  (mem_we),
   .mem_re  (mem_re),
   .sp_out  (sp_out)
);

// File: tb/test_callstack_seq.sv
`timescale 1ns/1ps
module test_callstack_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  op = '0;
   logic [15:0] pc_in = '0, sp_in = '0, pair_in = '0, target_in = '0;
   logic [7:0]  psw_in = '0;
   logic        busy, done, nmi_clr, mem_we, mem_re;
   logic [15:0] pc_out, sp_out, pair_out, mem_addr;
   logic [7:0]  psw_out, mem_wdata, mem_rdata;

   logic [7:0]  mem [0:1023];
   int          n_cmp = 0, n_bad = 0, acc_cnt = 0;
   logic [15:0] last_pair = '0;

   always #10 clk = ~clk;

   callstack_seq i_callstack_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
      .psw_in(psw_in), .sp_in(sp_in), .pair_in(pair_in), .target_in(target_in),
      .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
      .psw_out(psw_out), .pair_out(pair_out), .nmi_clr(nmi_clr),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [9:0] idx(input logic [15:0] a);
      return a[9:0];
   endfunction

   assign mem_rdata = mem[idx(mem_addr)];

   always @(posedge clk) begin
      if (mem_we) mem[idx(mem_addr)] <= mem_wdata;
      if (mem_we || mem_re) acc_cnt = acc_cnt + 1;
   end

   function automatic int exp_steps(input logic [3:0] o);
      case (o)
         4'd2: return 4;
         4'd3: return 5;
         4'd5, 4'd6: return 3;
         default: return 2;
      endcase
   endfunction

   function automatic logic [15:0] exp_len(input logic [3:0] o);
      case (o)
         4'd0: return 16'd3;
         4'd1: return 16'd2;
         default: return 16'd1;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'd0, 4'd1: return "R2";
         4'd2: return "R3";
         4'd3: return "R4";
         4'd4: return "R5";
         4'd5: return "R6";
         4'd6: return "R7";
         4'd7: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input logic [3:0] o, input logic [15:0] sp, input logic [15:0] pc,
                        input logic [7:0] st, input logic [15:0] pr, input logic [15:0] tg,
                        input bit interfere, input string extra);
      logic [15:0] ret, t, e_pc, e_sp, e_pair;
      logic [7:0]  e_psw;
      logic [7:0]  rd0, rd1, rd2, tb0, tb1, v0, v1;
      string       rq;
      int          cyc;
      rq   = (extra == "") ? req_of(o) : extra;
      ret  = pc + exp_len(o);
      t    = {8'h00, tg[7:0]};
      rd0  = mem[idx(sp)];
      rd1  = mem[idx(sp + 16'd1)];
      rd2  = mem[idx(sp + 16'd2)];
      tb0  = mem[idx(t)];
      tb1  = mem[idx(t + 16'd1)];
      v0   = mem[idx(16'h003E)];
      v1   = mem[idx(16'h003F)];
      e_psw  = st;
      e_pair = last_pair;
      case (o)
         4'd0, 4'd1: begin e_pc = tg;          e_sp = sp - 16'd2; end
         4'd2:       begin e_pc = {tb1, tb0};  e_sp = sp - 16'd2; end
         4'd3:       begin e_pc = {v1, v0};    e_sp = sp - 16'd3; end
         4'd4:       begin e_pc = {rd1, rd0};  e_sp = sp + 16'd2; end
         4'd5, 4'd6: begin e_pc = {rd1, rd0};  e_sp = sp + 16'd3; e_psw = rd2; end
         4'd7:       begin e_pc = pc;          e_sp = sp - 16'd2; end
         default:    begin e_pc = pc;          e_sp = sp + 16'd2; e_pair = {rd1, rd0}; end
      endcase

      @(negedge clk);
      op = o; sp_in = sp; pc_in = pc; psw_in = st; pair_in = pr; target_in = tg;
      start = 1'b1; acc_cnt = 0;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 40) begin
         if (interfere) begin
            start = 1'b1; op = 4'd7; sp_in = ~sp; pair_in = ~pr; pc_in = ~pc;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk("R10", "cycles to done", 32'(cyc), 32'(exp_steps(o)));
      chk("R10", "access count", 32'(acc_cnt), 32'(exp_steps(o)));
      chk(rq, "pc_out", 32'(pc_out), 32'(e_pc));
      chk(rq, "sp_out", 32'(sp_out), 32'(e_sp));
      chk(rq, "psw_out", 32'(psw_out), 32'(e_psw));
      chk(rq, "pair_out", 32'(pair_out), 32'(e_pair));
      chk((o == 4'd6) ? "R7" : "R6", "nmi_clr", 32'(nmi_clr), 32'(o == 4'd5));
      case (o)
         4'd0, 4'd1, 4'd2: begin
            chk(rq, "saved ret hi", 32'(mem[idx(sp - 16'd1)]), 32'(ret[15:8]));
            chk(rq, "saved ret lo", 32'(mem[idx(sp - 16'd2)]), 32'(ret[7:0]));
         end
         4'd3: begin
            chk(rq, "saved status", 32'(mem[idx(sp - 16'd1)]), 32'(st));
            chk(rq, "saved ret hi", 32'(mem[idx(sp - 16'd2)]), 32'(ret[15:8]));
            chk(rq, "saved ret lo", 32'(mem[idx(sp - 16'd3)]), 32'(ret[7:0]));
         end
         4'd7: begin
            chk(rq, "pushed hi", 32'(mem[idx(sp - 16'd1)]), 32'(pr[15:8]));
            chk(rq, "pushed lo", 32'(mem[idx(sp - 16'd2)]), 32'(pr[7:0]));
         end
         default: ;
      endcase
      last_pair = e_pair;
      @(negedge clk);
      chk(interfere ? "R11" : "R10", "done after pulse", 32'(done), 32'd0);
      chk(interfere ? "R11" : "R10", "busy after done", 32'(busy), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED1));
      for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);

      repeat (3) @(negedge clk);
      chk("R13", "busy in reset", 32'(busy), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13", "done", 32'(done), 32'd0);
      chk("R13", "busy", 32'(busy), 32'd0);
      chk("R13", "nmi_clr", 32'(nmi_clr), 32'd0);
      chk("R13", "mem strobes", 32'({mem_we, mem_re}), 32'd0);
      chk("R13", "pc_out", 32'(pc_out), 32'd0);
      chk("R13", "sp_out", 32'(sp_out), 32'd0);
      chk("R13", "psw_out", 32'(psw_out), 32'd0);
      chk("R13", "pair_out", 32'(pair_out), 32'd0);

      // illegal code is ignored (R1)
      @(negedge clk);
      op = 4'd12; start = 1'b1; acc_cnt = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk("R1", "done on illegal code", 32'(done), 32'd0);
         chk("R1", "busy on illegal code", 32'(busy), 32'd0);
      end
      start = 1'b0;
      chk("R1", "accesses on illegal code", 32'(acc_cnt), 32'd0);

      // directed: each code once at a quiet stack
      for (int o = 0; o < 9; o++)
         do_op(4'(o), 16'h0300, 16'h1234, 8'hA5, 16'hBEEF, 16'h0042, 1'b0, "");

      // wrap-around of the stack (R12)
      do_op(4'd7, 16'h0001, 16'h4000, 8'h11, 16'hCAFE, 16'h0000, 1'b0, "R12");
      do_op(4'd5, 16'hFFFE, 16'h4000, 8'h22, 16'h0000, 16'h0000, 1'b0, "R12");
      do_op(4'd3, 16'h0002, 16'hFFFF, 8'h33, 16'h0000, 16'h0000, 1'b0, "R12");

      // start held while busy (R11)
      do_op(4'd3, 16'h0280, 16'h7001, 8'h5C, 16'h1111, 16'h0000, 1'b1, "R11");
      do_op(4'd2, 16'h0290, 16'h00FE, 8'h01, 16'h2222, 16'h0050, 1'b1, "R11");

      // constrained random
      for (int n = 0; n < 300; n++) begin
         logic [3:0]  ro;
         logic [15:0] rsp, rtg;
         ro  = 4'($urandom % 9);
         rsp = 16'h0210 + 16'($urandom % 16'h01E0);
         rtg = {8'($urandom), 8'h40 + 8'(2 * ($urandom % 32))};
         do_op(ro, rsp, 16'($urandom), 8'($urandom), 16'($urandom), rtg, 1'b0, "");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule